// File: doc/BRIEF.md
# Pipelined Multiplier with MSB-Truncated Result

This block multiplies two integer operands whose widths are set independently, treating both as unsigned or both as two's-complement signed according to one elaboration setting. Two operand-source variants replace the second input. In the squaring variant the first operand is multiplied by itself. In the fixed-coefficient variant an elaboration-time constant of the second operand's width is used. In both variants the second input port has no effect on the result.

The result width is either derived automatically as the sum of the two effective operand widths, or set explicitly. An explicit width smaller than the full product keeps only the upper bits of the product. An explicit width larger than the full product extends it with sign or zero bits. The result passes through a configurable number of register stages. Every stage shares a clock enable, a synchronous clear and an asynchronous clear. A depth of zero gives a purely combinational path.

There is no control state machine: the datapath is operand selection, full-width multiply, MSB trim and a shift pipeline. The only enumerated choice is the operand source, which is fixed at elaboration: port, self (squaring) or constant.

Top module: `msb_multiplier`

## Requirements
- R1: With IS_SIGNED=0 both operands are read as unsigned; with IS_SIGNED=1 both are read as two's complement, and the product is the exact integer product of the two values.
- R2: With RES_W=0 the output width equals the sum of the effective operand widths (A_W+B_W, or 2*A_W when squaring) and carries the whole product.
- R3: When RES_W is nonzero and smaller than the full product width F, p_out equals bits [F-1 : F-RES_W] of the product taken at width F. For signed operands this is the product shifted right arithmetically by F-RES_W.
- R4: When RES_W exceeds F, the product fills bits [F-1:0] of p_out. The upper bits copy product bit F-1 when signed and are zero when unsigned.
- R5: With SQUARE=1 the result is a_in times a_in with a full width of 2*A_W, and b_in has no effect on p_out.
- R6: With CONST_B=1 (and SQUARE=0) the second operand is the B_CONST parameter, and b_in has no effect on p_out.
- R7: With LATENCY=L>=1, the operands present at a rising edge with ce high appear on p_out after the L-th such edge. With LATENCY=0, p_out follows the inputs combinationally.
- R8: A rising edge with ce low and sclr low changes no stage, so p_out holds its value.
- R9: A rising edge with sclr high clears every stage to zero whether ce is high or low, and takes precedence over the shift.
- R10: While aclr is high, every stage is zero at once, without waiting for a clock edge; this is the reset state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for the pipeline stages |
| aclr | input | 1 | Asynchronous clear of all stages, active high |
| sclr | input | 1 | Synchronous clear of all stages, active high, not gated by ce |
| ce | input | 1 | Clock enable; when low the pipeline holds |
| a_in | input | A_W | First operand |
| b_in | input | B_W | Second operand; unused in squaring and constant modes |
| p_out | output | OUT_W | Product, full width or MSB-truncated or extended |

## Verification
The bound checker watches the pipeline control on every cycle. It checks that a stalled edge leaves p_out unchanged, that an edge with sclr set leaves p_out at zero, and that p_out is zero whenever aclr is high. In a combinational squaring or constant configuration it also checks that p_out stays steady while a_in does, whatever b_in does. The arithmetic itself can only be shown by the bench's scenarios. These are exhaustive operand sweeps over five small configurations (unsigned automatic width, signed truncation, signed squaring, constant coefficient with truncation, and signed extension), streamed back to back, so that each product is compared at exactly its configured latency. Directed sequences then show hold under a stall, clearing under sclr with ce low, and an aclr asserted between edges.

// File: rtl/msb_mult_pkg.sv
package msb_mult_pkg;

    typedef enum logic [1:0] {
        SRC_PORT  = 2'd0,
        SRC_SELF  = 2'd1,
        SRC_CONST = 2'd2
    } bsrc_e;

    // Squaring wins if both variants are requested.
    function automatic bsrc_e pick_src(input bit square, input bit const_b);
        if (square)
            return SRC_SELF;
        else if (const_b)
            return SRC_CONST;
        else
            return SRC_PORT;
    endfunction

endpackage

// File: rtl/msb_mult_operand.sv
module msb_mult_operand import msb_mult_pkg::*; #(
    parameter int              A_W     = 8,
    parameter int              B_W     = 8,
    parameter int              EB_W    = 8,
    parameter bsrc_e           SRC     = SRC_PORT,
    parameter logic [B_W-1:0]  B_CONST = '0
) (
    input  logic [A_W-1:0]  a_i,
    input  logic [B_W-1:0]  b_i,
    output logic [EB_W-1:0] b_o
);

    case (SRC)
        SRC_SELF: begin : g_self
            assign b_o = a_i;
            logic unused_b;
            assign unused_b = ^b_i;
        end
        SRC_CONST: begin : g_const
            assign b_o = B_CONST;
            logic unused_ab;
            assign unused_ab = ^{a_i, b_i};
        end
        default: begin : g_port
            assign b_o = b_i;
            logic unused_a;
            assign unused_a = ^a_i;
        end
    endcase

endmodule

// File: rtl/msb_mult_product.sv
module msb_mult_product #(
    parameter int A_W       = 8,
    parameter int B_W       = 8,
    parameter bit IS_SIGNED = 1'b0,
    localparam int FW       = A_W + B_W
) (
    input  logic [A_W-1:0] a_i,
    input  logic [B_W-1:0] b_i,
    output logic [FW-1:0]  p_o
);

    logic [FW-1:0] a_ext;
    logic [FW-1:0] b_ext;

    // Both operands are widened to the product width first; the low FW bits
    // of the widened product are exact for either signedness.
    if (IS_SIGNED) begin : g_sext
        assign a_ext = {{(FW-A_W){a_i[A_W-1]}}, a_i};
        assign b_ext = {{(FW-B_W){b_i[B_W-1]}}, b_i};
    end else begin : g_zext
        assign a_ext = {{(FW-A_W){1'b0}}, a_i};
        assign b_ext = {{(FW-B_W){1'b0}}, b_i};
    end

    assign p_o = a_ext * b_ext;

endmodule

// File: rtl/msb_mult_trim.sv
module msb_mult_trim #(
    parameter int FW        = 16,
    parameter int OW        = 16,
    parameter bit IS_SIGNED = 1'b0
) (
    input  logic [FW-1:0] p_i,
    output logic [OW-1:0] r_o
);

    if (OW < FW) begin : g_msb
        assign r_o = p_i[FW-1 -: OW];
        logic unused_lsb;
        assign unused_lsb = ^p_i[FW-OW-1:0];
    end else if (OW == FW) begin : g_full
        assign r_o = p_i;
    end else if (IS_SIGNED) begin : g_sign_fill
        assign r_o = {{(OW-FW){p_i[FW-1]}}, p_i};
    end else begin : g_zero_fill
        assign r_o = {{(OW-FW){1'b0}}, p_i};
    end

endmodule

// File: rtl/msb_mult_pipe.sv
module msb_mult_pipe #(
    parameter int W     = 16,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         aclr,
    input  logic         sclr,
    input  logic         ce,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    if (DEPTH == 0) begin : g_comb
        assign q_o = d_i;
        logic unused_ctl;
        assign unused_ctl = ^{clk, aclr, sclr, ce};
    end else begin : g_regs
        logic [W-1:0] stg [DEPTH];

        always_ff @(posedge clk or posedge aclr) begin
            if (aclr) begin
                for (int i = 0; i < DEPTH; i++)
                    stg[i] <= '0;
            end else if (sclr) begin
                for (int i = 0; i < DEPTH; i++)
                    stg[i] <= '0;
            end else if (ce) begin
                stg[0] <= d_i;
                for (int i = 1; i < DEPTH; i++)
                    stg[i] <= stg[i-1];
            end
        end

        assign q_o = stg[DEPTH-1];
    end

endmodule

// File: rtl/msb_multiplier.sv
module msb_multiplier import msb_mult_pkg::*; #(
    parameter int             A_W       = 8,
    parameter int             B_W       = 8,
    parameter int             RES_W     = 16,
    parameter bit             IS_SIGNED = 1'b0,
    parameter bit             SQUARE    = 1'b0,
    parameter bit             CONST_B   = 1'b0,
    parameter logic [B_W-1:0] B_CONST   = '0,
    parameter int             LATENCY   = 1,
    localparam bsrc_e         SRC       = pick_src(SQUARE, CONST_B),
    localparam int            EB_W      = (SRC == SRC_SELF) ? A_W : B_W,
    localparam int            FULL_W    = A_W + EB_W,
    localparam int            OUT_W     = (RES_W == 0) ? FULL_W : RES_W
) (
    input  logic             clk,
    input  logic             aclr,
    input  logic             sclr,
    input  logic             ce,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    output logic [OUT_W-1:0] p_out
);

    logic [EB_W-1:0]   b_eff;
    logic [FULL_W-1:0] prod_full;
    logic [OUT_W-1:0]  prod_trim;

    msb_mult_operand #(
        .A_W     (A_W),
        .B_W     (B_W),
        .EB_W    (EB_W),
        .SRC     (SRC),
        .B_CONST (B_CONST)
    ) u_operand (
        .a_i (a_in),
        .b_i (b_in),
        .b_o (b_eff)
    );

    msb_mult_product #(
        .A_W       (A_W),
        .B_W       (EB_W),
        .IS_SIGNED (IS_SIGNED)
    ) u_product (
        .a_i (a_in),
        .b_i (b_eff),
        .p_o (prod_full)
    );

    // Trimming ahead of the stages keeps each stage OUT_W bits wide.
    msb_mult_trim #(
        .FW        (FULL_W),
        .OW        (OUT_W),
        .IS_SIGNED (IS_SIGNED)
    ) u_trim (
        .p_i (prod_full),
        .r_o (prod_trim)
    );

    msb_mult_pipe #(
        .W     (OUT_W),
        .DEPTH (LATENCY)
    ) u_pipe (
        .clk  (clk),
        .aclr (aclr),
        .sclr (sclr),
        .ce   (ce),
        .d_i  (prod_trim),
        .q_o  (p_out)
    );

endmodule

// File: rtl/msb_multiplier_chk.sv
module msb_multiplier_chk #(
    parameter int A_W      = 8,
    parameter int OUT_W    = 16,
    parameter int LATENCY  = 1,
    parameter bit IGNORE_B = 1'b0
) (
    input logic             clk,
    input logic             aclr,
    input logic             sclr,
    input logic             ce,
    input logic [A_W-1:0]   a_in,
    input logic [OUT_W-1:0] p_out
);

    if (LATENCY > 0) begin : g_seq
        // R8
        hold_when_stalled_chk: assert property (@(posedge clk) disable iff (aclr)
            (!$past(aclr) && !$past(ce) && !$past(sclr)) |-> $stable(p_out));

        // R9
        sync_clear_zero_chk: assert property (@(posedge clk) disable iff (aclr)
            ($past(sclr) && !$past(aclr)) |-> (p_out == '0));

        // R10
        async_clear_zero_chk: assert property (@(posedge clk)
            aclr |-> (p_out == '0));

        logic unused_a;
        assign unused_a = ^a_in;
    end else begin : g_comb
        if (IGNORE_B) begin : g_ign
            // R5 R6
            b_no_effect_chk: assert property (@(posedge clk) disable iff (aclr)
                $stable(a_in) |-> $stable(p_out));
        end else begin : g_noign
            logic unused_a;
            assign unused_a = ^a_in;
        end
        logic unused_ctl;
        assign unused_ctl = ^{sclr, ce};
    end

endmodule

bind msb_multiplier msb_multiplier_chk #(
    .A_W      (A_W),
    .OUT_W    (OUT_W),
    .LATENCY  (LATENCY),
    .IGNORE_B (SQUARE || CONST_B)
) u_chk (
    .clk   (clk),
    .aclr  (aclr),
    .sclr  (sclr),
    .ce    (ce),
    .a_in  (a_in),
    .p_out (p_out)
);

// File: tb/msb_multiplier_bench.sv
`timescale 1ns/1ps
module msb_multiplier_bench;

    logic       clk  = 1'b0;
    logic       aclr = 1'b1;
    logic       sclr = 1'b0;
    logic       ce   = 1'b1;
    logic [3:0] a    = 4'h9;
    logic [3:0] b    = 4'h6;

    logic [6:0] p_main;
    logic [4:0] p_sgn;
    logic [7:0] p_sq;
    logic [5:0] p_cst;
    logic [7:0] p_wide;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [3:0] ha [0:299];
    logic [3:0] hb [0:299];

    always #10 clk = ~clk;

    // unsigned 4x3, automatic width 7, two stages
    msb_multiplier #(.A_W(4), .B_W(3), .RES_W(0), .IS_SIGNED(1'b0), .LATENCY(2)) u_msb_multiplier (
        .clk(clk), .aclr(aclr), .sclr(sclr), .ce(ce), .a_in(a), .b_in(b[2:0]), .p_out(p_main));

    // signed 4x4, top 5 of 8 bits, one stage
    msb_multiplier #(.A_W(4), .B_W(4), .RES_W(5), .IS_SIGNED(1'b1), .LATENCY(1)) u_msb_multiplier_sgn (
        .clk(clk), .aclr(aclr), .sclr(sclr), .ce(ce), .a_in(a), .b_in(b), .p_out(p_sgn));

    // signed squaring, automatic width 8, combinational
    msb_multiplier #(.A_W(4), .B_W(4), .RES_W(0), .IS_SIGNED(1'b1), .SQUARE(1'b1), .LATENCY(0)) u_msb_multiplier_sq (
        .clk(clk), .aclr(aclr), .sclr(sclr), .ce(ce), .a_in(a), .b_in(b), .p_out(p_sq));

    // unsigned times constant 11, top 6 of 8 bits, three stages
    msb_multiplier #(.A_W(4), .B_W(4), .RES_W(6), .IS_SIGNED(1'b0), .CONST_B(1'b1), .B_CONST(4'd11), .LATENCY(3)) u_msb_multiplier_cst (
        .clk(clk), .aclr(aclr), .sclr(sclr), .ce(ce), .a_in(a), .b_in(b), .p_out(p_cst));

    // signed 3x3 widened to 8 bits, one stage
    msb_multiplier #(.A_W(3), .B_W(3), .RES_W(8), .IS_SIGNED(1'b1), .LATENCY(1)) u_msb_multiplier_wide (
        .clk(clk), .aclr(aclr), .sclr(sclr), .ce(ce), .a_in(a[2:0]), .b_in(b[2:0]), .p_out(p_wide));

    function automatic int sx(input int v, input int w);
        return (v >= (1 << (w - 1))) ? v - (1 << w) : v;
    endfunction

    function automatic int fit(input int p, input int fw, input int rw);
        int sh;
        sh = (rw < fw) ? fw - rw : 0;
        return (p >>> sh) & ((1 << rw) - 1);
    endfunction

    function automatic int e_main(input int x, input int y); return fit(x * (y & 7), 7, 7); endfunction
    function automatic int e_sgn(input int x, input int y);  return fit(sx(x, 4) * sx(y, 4), 8, 5); endfunction
    function automatic int e_sq(input int x);                return fit(sx(x, 4) * sx(x, 4), 8, 8); endfunction
    function automatic int e_cst(input int x);               return fit(x * 11, 8, 6); endfunction
    function automatic int e_wide(input int x, input int y); return fit(sx(x & 7, 3) * sx(y & 7, 3), 6, 8); endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        int s_main, s_sgn, s_cst, s_wide;
        #1;
        // R10 reset state with nonzero operands present
        chk("R10 reset main", int'(p_main), 0);
        chk("R10 reset sgn",  int'(p_sgn),  0);
        chk("R10 reset cst",  int'(p_cst),  0);
        chk("R10 reset wide", int'(p_wide), 0);
        @(negedge clk);
        aclr = 1'b0;

        // exhaustive streamed sweep: R1 R2 R3 R4 R5 R6 R7
        for (int k = 0; k < 260; k++) begin
            @(negedge clk);
            if (k >= 2) chk("R1 R2 R7 main unsigned", int'(p_main), e_main(int'(ha[k-2]), int'(hb[k-2])));
            if (k >= 1) chk("R1 R3 R7 sgn truncated", int'(p_sgn),  e_sgn(int'(ha[k-1]), int'(hb[k-1])));
            if (k >= 3) chk("R6 R3 R7 cst truncated", int'(p_cst),  e_cst(int'(ha[k-3])));
            if (k >= 1) chk("R4 R7 wide extended",    int'(p_wide), e_wide(int'(ha[k-1]), int'(hb[k-1])));
            a = 4'(k);
            b = 4'((k >> 4) ^ (k * 5));
            ha[k] = a;
            hb[k] = b;
            #1;
            chk("R5 R2 R7 sq combinational", int'(p_sq), e_sq(int'(a)));
        end

        // R8 stall holds every stage
        @(negedge clk);
        ce = 1'b0;
        s_main = int'(p_main); s_sgn = int'(p_sgn); s_cst = int'(p_cst); s_wide = int'(p_wide);
        a = 4'd5;
        b = 4'd3;
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk("R8 hold main", int'(p_main), s_main);
            chk("R8 hold sgn",  int'(p_sgn),  s_sgn);
            chk("R8 hold cst",  int'(p_cst),  s_cst);
            chk("R8 hold wide", int'(p_wide), s_wide);
        end
        ce = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 resume main", int'(p_main), e_main(5, 3));
        chk("R7 resume sgn",  int'(p_sgn),  e_sgn(5, 3));
        chk("R7 resume cst",  int'(p_cst),  e_cst(5));
        chk("R7 resume wide", int'(p_wide), e_wide(5, 3));

        // R9 synchronous clear with ce low
        ce = 1'b0;
        sclr = 1'b1;
        @(negedge clk);
        chk("R9 sclr main", int'(p_main), 0);
        chk("R9 sclr sgn",  int'(p_sgn),  0);
        chk("R9 sclr cst",  int'(p_cst),  0);
        chk("R9 sclr wide", int'(p_wide), 0);
        sclr = 1'b0;
        @(negedge clk);
        chk("R8 R9 cleared and stalled cst", int'(p_cst), 0);
        ce = 1'b1;
        b = 4'hF;
        #1;
        chk("R5 b ignored sq", int'(p_sq), e_sq(5));
        repeat (3) @(negedge clk);
        chk("R6 b ignored cst", int'(p_cst), e_cst(5));
        chk("R1 main new b",    int'(p_main), e_main(5, 15));

        // R10 asynchronous clear between edges
        #3;
        aclr = 1'b1;
        #1;
        chk("R10 aclr main", int'(p_main), 0);
        chk("R10 aclr sgn",  int'(p_sgn),  0);
        chk("R10 aclr cst",  int'(p_cst),  0);
        chk("R10 aclr wide", int'(p_wide), 0);
        @(negedge clk);
        aclr = 1'b0;
        @(negedge clk);
        chk("R7 after aclr sgn", int'(p_sgn), e_sgn(5, 15));

        done = 1'b1;
        finish_run();
    end

endmodule